// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects 64 maskable interrupt lines and one non-maskable line, and offers the processor core one request at a time, together with the vector number of the winning source. Each maskable line has an enable bit, a pending bit, an active bit, a 3-bit urgency value and a capture mode. In level mode a line raises its pending bit while it is high. In pulse mode a rising edge latches the pending bit. Software reaches all per-line state through a 32-bit word register port.

A programmable split point divides the urgency value into an upper group field and a lower sub field. Only the group field decides whether a request may interrupt a running handler. Each accepted handler pushes its preemption level onto a nesting stack, and each handler exit pops it. When a pending request beats the restored level at exit, the controller raises a tail-chain flag and presents that request without dropping back to base level.

Control is a three-state machine. `ST_IDLE` means no handler is running. `ST_RUN` means one or more handlers are nested. `ST_CHAIN` means a handler has just exited straight into another request. The transitions are as follows:
- accept: `ST_IDLE`/`ST_CHAIN` to `ST_RUN`.
- exit-to-chain: `ST_RUN`/`ST_CHAIN` to `ST_CHAIN`.
- exit-to-base: to `ST_IDLE` when the last entry pops and nothing chains.
- exit-nested: to `ST_RUN` when entries remain.
- chain-lost: `ST_CHAIN` to `ST_IDLE` or `ST_RUN` when the chained request disappears.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, every enable, pending, active, mode and urgency bit is 0, the split field is 0, `irq_req` is 0, `irq_vector` is 0 and `tail_chain` is 0.
- R2: The register word map is indexed by `reg_addr`, where word `w` (0 or 1) covers lines 32w..32w+31 with bit b meaning line 32w+b:
  - words 0–1: writing 1s sets enables; a read returns the enables.
  - words 2–3: writing 1s clears enables; a read returns the enables.
  - words 4–5: writing 1s sets pending bits; a read returns the pending bits.
  - words 6–7: writing 1s clears pending bits; a read returns the pending bits.
  - words 8–9: active bits, read-only.
  - words 10–11: mode, where 1 means pulse and 0 means level.
  - words 12–19: urgency. Line 8k+j sits in bits 4j+2..4j of word 12+k.
  - word 20: the split field in bits 1:0, which gives the number of low urgency bits that form the sub field. A written value above 3 is stored as 3.
  Writes take effect at the clock edge, and reads are combinational.
- R3: A pulse-mode line sets its pending bit one edge after a rising input, and the bit stays set after the input falls until it is cleared by software or by acceptance.
- R4: A level-mode line sets its pending bit at every edge where its input is high, and acceptance clears it.
- R5: Among lines that are pending, enabled and not active, the one with the lowest urgency value wins. A tie goes to the lowest line number. `irq_vector` gives the line number and `irq_vector` is 0 when `irq_req` is 0.
- R6: A new urgency value takes part in arbitration from the cycle after its write.
- R7: A request is raised only if its group field (urgency shifted right by the split) is strictly below that of the innermost running handler. The non-maskable line counts as a group below all others.
- R8: Exiting a handler (`irq_exit`) clears its active bit and restores the preemption level of the handler beneath it, or base level if none remains.
- R9: If at an exit a request beats the restored level, `tail_chain` is 1 from that edge until the request is accepted, and `irq_req` presents that request.
- R10: A rising edge on `nmi_in` latches a non-maskable request with vector 64, which ignores all enable bits, wins over every maskable line and preempts any maskable handler, but not a running non-maskable handler.
- R11: Pulsing `irq_ack` while `irq_req` is 1 accepts the shown vector: its active bit is set and its pending bit is cleared at that edge.
- R12: The nesting stack never overflows: a push never happens with the stack full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Maskable interrupt lines |
| nmi_in | input | 1 | Non-maskable interrupt line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq_ack | input | 1 | Core accepts the presented vector |
| irq_exit | input | 1 | Core leaves the innermost handler |
| irq_req | output | 1 | Request to the core |
| irq_vector | output | 7 | Vector of the winning request (64 = non-maskable) |
| tail_chain | output | 1 | Exit moved directly into another request |

## Verification
On every clock cycle, the assertions check the following:
- A non-maskable request is always shown when it can preempt.
- A shown maskable vector is always enabled and pending.
- An accepted vector becomes active.
- `ST_IDLE` implies an empty stack.
- The tail-chain flag only rises after an exit.
- The stack never overflows.

Whether the right line wins a tie or a changed urgency, and whether the group split blocks an equal-group request, can only be shown by the bench's scenarios. The same holds for whether popping restores the exact earlier threshold and whether exit chains into the correct request, since these depend on sequences of register writes, acknowledges and exits.

// File: rtl/nic_pkg.sv
package nic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_CHAIN = 2'd2
    } nic_state_e;
endpackage

// File: rtl/nic_regfile.sv
module nic_regfile #(
    parameter int NUM_LINES = 64,
    parameter int PRIO_W    = 3,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 5,
    parameter int VEC_W     = 7,
    parameter int SPLIT_W   = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_LINES-1:0]             irq_in,
    input  logic                             nmi_in,
    input  logic                             reg_we,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic [WORD_W-1:0]                reg_wdata,
    output logic [WORD_W-1:0]                reg_rdata,
    input  logic                             take_valid,
    input  logic [VEC_W-1:0]                 take_vec,
    input  logic                             drop_valid,
    input  logic [VEC_W-1:0]                 drop_vec,
    output logic [NUM_LINES-1:0]             enable_o,
    output logic [NUM_LINES-1:0]             pending_o,
    output logic [NUM_LINES-1:0]             active_o,
    output logic [NUM_LINES-1:0][PRIO_W-1:0] prio_o,
    output logic [SPLIT_W-1:0]               split_o,
    output logic                             nmi_pend_o
);
    localparam int NW     = NUM_LINES / WORD_W;
    localparam int LPW    = WORD_W / 4;
    localparam int PWORDS = NUM_LINES / LPW;
    localparam int A_ENS  = 0;
    localparam int A_ENC  = NW;
    localparam int A_PNS  = 2 * NW;
    localparam int A_PNC  = 3 * NW;
    localparam int A_ACT  = 4 * NW;
    localparam int A_MOD  = 5 * NW;
    localparam int A_PRI  = 6 * NW;
    localparam int A_CTL  = 6 * NW + PWORDS;
    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_LINES);

    logic [NUM_LINES-1:0] en_q, pend_q, act_q, mode_q, irq_q;
    logic [NUM_LINES-1:0] en_d, pend_d, act_d, mode_d;
    logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q, prio_d;
    logic [SPLIT_W-1:0] split_q, split_d;
    logic nmi_q, nmi_pend_q;

    always_comb begin
        en_d = en_q; pend_d = pend_q; act_d = act_q;
        mode_d = mode_q; prio_d = prio_q; split_d = split_q;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (mode_q[i]) begin
                if (irq_in[i] && !irq_q[i]) pend_d[i] = 1'b1;
            end else if (irq_in[i]) begin
                pend_d[i] = 1'b1;
            end
        end
        if (reg_we) begin
            for (int w = 0; w < NW; w++) begin
                for (int b = 0; b < WORD_W; b++) begin
                    if (reg_addr == ADDR_W'(A_ENS + w) && reg_wdata[b]) en_d[w*WORD_W+b] = 1'b1;
                    if (reg_addr == ADDR_W'(A_ENC + w) && reg_wdata[b]) en_d[w*WORD_W+b] = 1'b0;
                    if (reg_addr == ADDR_W'(A_PNS + w) && reg_wdata[b]) pend_d[w*WORD_W+b] = 1'b1;
                    if (reg_addr == ADDR_W'(A_PNC + w) && reg_wdata[b]) pend_d[w*WORD_W+b] = 1'b0;
                    if (reg_addr == ADDR_W'(A_MOD + w)) mode_d[w*WORD_W+b] = reg_wdata[b];
                end
            end
            for (int k = 0; k < PWORDS; k++) begin
                for (int j = 0; j < LPW; j++) begin
                    if (reg_addr == ADDR_W'(A_PRI + k)) prio_d[k*LPW+j] = reg_wdata[4*j +: PRIO_W];
                end
            end
            if (reg_addr == ADDR_W'(A_CTL))
                split_d = (reg_wdata > WORD_W'(PRIO_W)) ? SPLIT_W'(PRIO_W) : reg_wdata[SPLIT_W-1:0];
        end
        for (int i = 0; i < NUM_LINES; i++) begin
            if (take_valid && take_vec == VEC_W'(i)) begin
                act_d[i]  = 1'b1;
                pend_d[i] = 1'b0;
            end
            if (drop_valid && drop_vec == VEC_W'(i)) act_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0; pend_q <= '0; act_q <= '0; mode_q <= '0; irq_q <= '0;
            prio_q <= '0; split_q <= '0; nmi_q <= 1'b0; nmi_pend_q <= 1'b0;
        end else begin
            en_q <= en_d; pend_q <= pend_d; act_q <= act_d; mode_q <= mode_d;
            prio_q <= prio_d; split_q <= split_d; irq_q <= irq_in; nmi_q <= nmi_in;
            if (nmi_in && !nmi_q) nmi_pend_q <= 1'b1;
            else if (take_valid && take_vec == NMI_VEC) nmi_pend_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < NW; w++) begin
            if (reg_addr == ADDR_W'(A_ENS + w) || reg_addr == ADDR_W'(A_ENC + w))
                reg_rdata = en_q[w*WORD_W +: WORD_W];
            if (reg_addr == ADDR_W'(A_PNS + w) || reg_addr == ADDR_W'(A_PNC + w))
                reg_rdata = pend_q[w*WORD_W +: WORD_W];
            if (reg_addr == ADDR_W'(A_ACT + w)) reg_rdata = act_q[w*WORD_W +: WORD_W];
            if (reg_addr == ADDR_W'(A_MOD + w)) reg_rdata = mode_q[w*WORD_W +: WORD_W];
        end
        for (int k = 0; k < PWORDS; k++) begin
            for (int j = 0; j < LPW; j++) begin
                if (reg_addr == ADDR_W'(A_PRI + k)) reg_rdata[4*j +: PRIO_W] = prio_q[k*LPW+j];
            end
        end
        if (reg_addr == ADDR_W'(A_CTL)) reg_rdata[SPLIT_W-1:0] = split_q;
    end

    assign enable_o   = en_q;
    assign pending_o  = pend_q;
    assign active_o   = act_q;
    assign prio_o     = prio_q;
    assign split_o    = split_q;
    assign nmi_pend_o = nmi_pend_q;

    // R11: an accepted maskable vector is active on the following cycle
    p_take_sets_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && take_vec != NMI_VEC && !drop_valid)
        |=> act_q[$past(take_vec[$clog2(NUM_LINES)-1:0])]);
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
    parameter int NUM_LINES = 64,
    parameter int PRIO_W    = 3,
    parameter int VEC_W     = 7,
    parameter int LVL_W     = 4,
    parameter int SPLIT_W   = 2
) (
    input  logic [NUM_LINES-1:0]             cand_mask,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    input  logic [SPLIT_W-1:0]               split,
    input  logic                             nmi_pend,
    output logic                             win_valid,
    output logic [VEC_W-1:0]                 win_vec,
    output logic [LVL_W-1:0]                 win_lvl
);
    localparam int IDX_W = $clog2(NUM_LINES);

    logic              best_ok;
    logic [IDX_W-1:0]  best_idx;
    logic [PRIO_W-1:0] best_pr;

    always_comb begin
        best_ok  = 1'b0;
        best_idx = '0;
        best_pr  = '1;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cand_mask[i] && (!best_ok || prio[i] < best_pr)) begin
                best_ok  = 1'b1;
                best_pr  = prio[i];
                best_idx = IDX_W'(i);
            end
        end
        if (nmi_pend) begin
            win_valid = 1'b1;
            win_vec   = VEC_W'(NUM_LINES);
            win_lvl   = '0;
        end else begin
            win_valid = best_ok;
            win_vec   = best_ok ? VEC_W'(best_idx) : '0;
            win_lvl   = LVL_W'(best_pr >> split) + LVL_W'(1);
        end
    end
endmodule

// File: rtl/nic_nest_stack.sv
module nic_nest_stack #(
    parameter int DEPTH = 9,
    parameter int VEC_W = 7,
    parameter int LVL_W = 4,
    parameter int SP_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [VEC_W-1:0] push_vec,
    input  logic [LVL_W-1:0] push_lvl,
    output logic [VEC_W-1:0] top_vec,
    output logic [LVL_W-1:0] top_lvl,
    output logic [LVL_W-1:0] under_lvl,
    output logic [SP_W-1:0]  depth
);
    logic [DEPTH-1:0][VEC_W-1:0] vec_q;
    logic [DEPTH-1:0][LVL_W-1:0] lvl_q;
    logic [SP_W-1:0] sp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0; vec_q <= '0; lvl_q <= '0;
        end else if (pop && sp != '0) begin
            sp <= sp - SP_W'(1);
        end else if (push && sp != SP_W'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (sp == SP_W'(i)) begin
                    vec_q[i] <= push_vec;
                    lvl_q[i] <= push_lvl;
                end
            end
            sp <= sp + SP_W'(1);
        end
    end

    always_comb begin
        top_vec = '0; top_lvl = '1; under_lvl = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (sp == SP_W'(i + 1)) begin
                top_vec = vec_q[i];
                top_lvl = lvl_q[i];
            end
            if (sp == SP_W'(i + 2)) under_lvl = lvl_q[i];
        end
    end

    assign depth = sp;

    // R12: no push into a full stack
    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> sp != SP_W'(DEPTH));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int PRIO_W    = 3,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_LINES-1:0]            irq_in,
    input  logic                            nmi_in,
    input  logic                            reg_we,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic [WORD_W-1:0]               reg_wdata,
    output logic [WORD_W-1:0]               reg_rdata,
    input  logic                            irq_ack,
    input  logic                            irq_exit,
    output logic                            irq_req,
    output logic [$clog2(NUM_LINES+1)-1:0]  irq_vector,
    output logic                            tail_chain
);
    localparam int VEC_W   = $clog2(NUM_LINES + 1);
    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int LVL_W   = PRIO_W + 1;
    localparam int SPLIT_W = $clog2(PRIO_W + 1);
    localparam int DEPTH   = (1 << PRIO_W) + 1;
    localparam int SP_W    = $clog2(DEPTH + 1);
    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_LINES);

    nic_state_e state_q, state_d;

    logic [NUM_LINES-1:0] enable, pending, active;
    logic [NUM_LINES-1:0][PRIO_W-1:0] prio;
    logic [SPLIT_W-1:0] split;
    logic nmi_pend, cand_valid, do_push, do_pop, chain_ok, stk_empty;
    logic [VEC_W-1:0] cand_vec, top_vec;
    logic [LVL_W-1:0] cand_lvl, top_lvl, under_lvl;
    logic [SP_W-1:0] depth;

    nic_regfile #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .WORD_W(WORD_W),
                  .ADDR_W(ADDR_W), .VEC_W(VEC_W), .SPLIT_W(SPLIT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .take_valid(do_push), .take_vec(cand_vec), .drop_valid(do_pop), .drop_vec(top_vec),
        .enable_o(enable), .pending_o(pending), .active_o(active), .prio_o(prio),
        .split_o(split), .nmi_pend_o(nmi_pend));

    nic_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .VEC_W(VEC_W),
                  .LVL_W(LVL_W), .SPLIT_W(SPLIT_W)) arb_i (
        .cand_mask(pending & enable & ~active), .prio(prio), .split(split),
        .nmi_pend(nmi_pend), .win_valid(cand_valid), .win_vec(cand_vec), .win_lvl(cand_lvl));

    nic_nest_stack #(.DEPTH(DEPTH), .VEC_W(VEC_W), .LVL_W(LVL_W), .SP_W(SP_W)) stk_i (
        .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop),
        .push_vec(cand_vec), .push_lvl(cand_lvl),
        .top_vec(top_vec), .top_lvl(top_lvl), .under_lvl(under_lvl), .depth(depth));

    assign stk_empty = (depth == '0);
    assign do_pop    = irq_exit && !stk_empty;
    assign do_push   = irq_ack && irq_req && !do_pop;
    assign chain_ok  = cand_valid && (cand_lvl < under_lvl);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (do_push) state_d = ST_RUN;
            ST_RUN: begin
                if (do_pop)
                    state_d = chain_ok ? ST_CHAIN
                            : (depth == SP_W'(1) ? ST_IDLE : ST_RUN);
            end
            ST_CHAIN: begin
                if (do_pop)
                    state_d = chain_ok ? ST_CHAIN
                            : (depth == SP_W'(1) ? ST_IDLE : ST_RUN);
                else if (do_push)  state_d = ST_RUN;
                else if (!irq_req) state_d = stk_empty ? ST_IDLE : ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_req    = cand_valid && (cand_lvl < top_lvl);
        irq_vector = irq_req ? cand_vec : '0;
        tail_chain = (state_q == ST_CHAIN);
    end

    // R8: base state only with no handler on the stack
    p_idle_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> stk_empty);
    // R10: a latched non-maskable request is shown unless one is already running
    p_nmi_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && top_lvl != '0) |-> (irq_req && irq_vector == NMI_VEC));
    // R5: a shown maskable vector is enabled and pending
    p_winner_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_vector != NMI_VEC)
        |-> (enable[irq_vector[IDX_W-1:0]] && pending[irq_vector[IDX_W-1:0]]));
    // R9: the chain flag rises only after an exit
    p_chain_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tail_chain) |-> $past(irq_exit));
endmodule

// File: tb/nest_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        nmi_in = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_ack = 1'b0;
    logic        irq_exit = 1'b0;
    logic        irq_req;
    logic [6:0]  irq_vector;
    logic        tail_chain;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    nest_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_exit(irq_exit), .irq_req(irq_req),
        .irq_vector(irq_vector), .tail_chain(tail_chain));

    typedef enum logic [1:0] {OP_WR = 2'd0, OP_RD = 2'd1, OP_RQ = 2'd2} op_e;
    typedef struct packed {
        op_e         op;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  rq;
    } vec_t;

    // writes, register readbacks and request checks ({req, vector})
    localparam int NVEC = 23;
    localparam vec_t TBL [NVEC] = '{
        '{OP_WR, 5'd0,  32'h5,      32'h0,   8'd2},
        '{OP_RD, 5'd0,  32'h0,      32'h5,   8'd2},   // R2 enable set
        '{OP_WR, 5'd2,  32'h1,      32'h0,   8'd2},
        '{OP_RD, 5'd0,  32'h0,      32'h4,   8'd2},   // R2 enable clear
        '{OP_RD, 5'd2,  32'h0,      32'h4,   8'd2},
        '{OP_WR, 5'd12, 32'h1500,   32'h0,   8'd2},
        '{OP_RD, 5'd12, 32'h0,      32'h1500,8'd2},   // R2 urgency readback
        '{OP_WR, 5'd0,  32'hF,      32'h0,   8'd5},
        '{OP_WR, 5'd4,  32'hC,      32'h0,   8'd5},
        '{OP_RQ, 5'd0,  32'h0,      32'h83,  8'd5},   // R5 line 3 urgency 1 wins
        '{OP_WR, 5'd12, 32'h6500,   32'h0,   8'd6},
        '{OP_RQ, 5'd0,  32'h0,      32'h82,  8'd6},   // R6 new urgency used
        '{OP_WR, 5'd12, 32'h5500,   32'h0,   8'd5},
        '{OP_RQ, 5'd0,  32'h0,      32'h82,  8'd5},   // R5 tie: lower line
        '{OP_WR, 5'd2,  32'h4,      32'h0,   8'd5},
        '{OP_RQ, 5'd0,  32'h0,      32'h83,  8'd5},   // R5 disabled line skipped
        '{OP_WR, 5'd6,  32'h8,      32'h0,   8'd5},
        '{OP_RQ, 5'd0,  32'h0,      32'h0,   8'd5},
        '{OP_RD, 5'd4,  32'h0,      32'h4,   8'd2},
        '{OP_WR, 5'd6,  32'h4,      32'h0,   8'd2},
        '{OP_RD, 5'd4,  32'h0,      32'h0,   8'd2},
        '{OP_WR, 5'd20, 32'h7,      32'h0,   8'd2},
        '{OP_RD, 5'd20, 32'h0,      32'h3,   8'd2}    // R2 split clamp
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic rq(input string tag, input logic [31:0] exp);
        #1;
        chk(tag, {24'h0, irq_req, irq_vector}, exp);
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        #1;
    endtask

    task automatic leave();
        @(negedge clk); irq_exit = 1'b1;
        @(negedge clk); irq_exit = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; irq_in = '0; nmi_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        rq("R1 request", 32'h0);
        chk("R1 tail_chain", {31'h0, tail_chain}, 32'h0);
        rd("R1 enables", 5'd0, 32'h0);
        rd("R1 pending", 5'd4, 32'h0);
        rd("R1 active", 5'd8, 32'h0);
        rd("R1 split", 5'd20, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            unique case (TBL[i].op)
                OP_WR: wr(TBL[i].addr, TBL[i].data);
                OP_RD: rd($sformatf("R%0d vec %0d", TBL[i].rq, i), TBL[i].addr, TBL[i].exp);
                OP_RQ: rq($sformatf("R%0d vec %0d", TBL[i].rq, i), TBL[i].exp);
                default: ;
            endcase
        end

        // R3 pulse capture
        do_reset();
        wr(5'd10, 32'h20);
        wr(5'd0, 32'h20);
        @(negedge clk); irq_in[5] = 1'b1;
        @(negedge clk); rq("R3 pulse latched", 32'h85);
        irq_in[5] = 1'b0;
        repeat (3) @(negedge clk);
        rd("R3 pending sticky", 5'd4, 32'h20);
        wr(5'd6, 32'h20);
        rd("R3 pending cleared", 5'd4, 32'h0);
        rq("R3 no request", 32'h0);

        // R4 level capture, R11 acceptance
        wr(5'd0, 32'h40);
        @(negedge clk); irq_in[6] = 1'b1;
        @(negedge clk); rq("R4 level request", 32'h86);
        irq_ack = 1'b1; irq_in[6] = 1'b0;
        @(negedge clk); irq_ack = 1'b0; #1;
        rd("R11 active set", 5'd8, 32'h40);
        rd("R4 pending cleared", 5'd4, 32'h0);
        rq("R11 no request while active", 32'h0);
        leave();
        rd("R8 active cleared", 5'd8, 32'h0);
        chk("R8 no chain", {31'h0, tail_chain}, 32'h0);

        // R7 group split, R8 nesting, R9 tail chain
        do_reset();
        wr(5'd20, 32'h1);
        wr(5'd13, 32'h0032_5400);
        wr(5'd0, 32'h3C00);
        wr(5'd4, 32'h800);
        rq("R7 line 11 shown", 32'h8B);
        ack();
        wr(5'd4, 32'h400);
        rq("R7 equal group blocked", 32'h0);
        wr(5'd4, 32'h2000);
        rq("R7 lower group preempts", 32'h8D);
        ack();
        rq("R7 nested blocks", 32'h0);
        leave();
        chk("R8 restored no chain", {31'h0, tail_chain}, 32'h0);
        rq("R8 restored threshold", 32'h0);
        rd("R8 outer still active", 5'd8, 32'h800);
        leave();
        chk("R9 chain flag", {31'h0, tail_chain}, 32'h1);
        rq("R9 chained request", 32'h8A);
        ack();
        chk("R9 chain flag cleared", {31'h0, tail_chain}, 32'h0);
        rd("R11 chained active", 5'd8, 32'h400);
        leave();
        rq("R8 base", 32'h0);

        // R10 non-maskable
        do_reset();
        wr(5'd0, 32'h0010_0000);
        wr(5'd4, 32'h0010_0000);
        rq("R5 line 20", 32'h94);
        ack();
        @(negedge clk); nmi_in = 1'b1;
        @(negedge clk); rq("R10 nmi preempts", 32'hC0);
        ack();
        nmi_in = 1'b0;
        @(negedge clk); nmi_in = 1'b1;
        @(negedge clk); rq("R10 nmi not self-preempting", 32'h0);
        leave();
        chk("R9 chain into nmi", {31'h0, tail_chain}, 32'h1);
        rq("R10 nmi chained", 32'hC0);
        ack();
        leave();
        leave();
        rq("R8 all exited", 32'h0);
        rd("R8 no active", 5'd8, 32'h0);
        chk("R8 flag low", {31'h0, tail_chain}, 32'h0);

        finish_run();
    end
endmodule